// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a memory-mapped watchdog. Software selects a timeout from sixteen power-of-two lengths, sets the enable bit, and then has to keep writing a fixed key to a restart register before the counter runs out. Once the watchdog is enabled, software cannot disable it. Only the block's own reset returns it to the idle state.

Two response modes are available. In direct mode, the first expiry starts a system reset pulse. In two-stage mode, the first expiry raises an interrupt and reloads the counter. If that interrupt is still pending when the counter runs out a second time, the reset pulse is issued. The maximum time from the last service to reset is therefore two periods. After the reset pulse the counter stays frozen until the block itself is reset. Registers are reached through a single-cycle port: a write takes effect at the next clock edge, and read data is combinational from the address. A read-only parameter register reports that the fixed power-of-two period set is in use.

Top module: `wdt_top`

## Requirements
- R1: After rst_ni, the control word (offset 0x00) reads 0, the counter (0x08) reads 0, interrupt status (0x10) reads 0, and irq_o and sys_rst_o are low. The counter does not run until it is enabled.
- R2: Control bit 0 is enable and bit 1 is mode (0 = direct reset, 1 = interrupt then reset). Writing 1 to bit 0 enables the watchdog. A later write of 0 to bit 0 leaves it at 1.
- R3: A period index k selects a length of 2^(BASE_EXP+k) cycles. The first period after enabling uses bits [7:4] of the range word (0x04). The cycle after the enabling write, the counter reads length-1, and it then falls by one every cycle.
- R4: Writing exactly 0x76 (the whole 32-bit word) to offset 0x0C reloads the counter with length-1 for the index in range bits [3:0]. Any other value written there has no effect.
- R5: A valid restart clears a pending interrupt.
- R6: In direct mode, the edge after the counter reads 0 raises sys_rst_o. It stays high for exactly RST_CYC cycles.
- R7: In two-stage mode, the first expiry sets the interrupt (irq_o and bit 0 of 0x10) and reloads the counter with the restart length. An expiry while the interrupt is still pending raises sys_rst_o as in R6.
- R8: A read of offset 0x14 clears the pending interrupt. After such a clear, the next expiry only sets the interrupt again.
- R9: After the reset pulse, the counter holds at 0 and sys_rst_o stays low. Restarts are ignored until rst_ni is asserted.
- R10: A write to the range word while the counter runs does not change the running count. The new indices apply from the next reload.
- R11: Offset 0xF4 reads 0x40 (bit 6 set: fixed power-of-two periods) and ignores writes. Unmapped offsets read 0.
- R12: A valid restart in the same cycle as an expiry wins. The counter reloads and no interrupt or reset occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i, combinational |
| irq_o | output | 1 | Pending first-stage interrupt |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
The bench builds the block with BASE_EXP=2 and RST_CYC=3. With these values the shortest periods last only 4 to 64 cycles, so direct expiries, two-stage expiries, restart races and the whole reset pulse all occur many times in a short run. Index 15 still gives 2^17 cycles. The bench reaches that value by reading back the loaded counter rather than waiting for the expiry. Random traffic runs against a cycle model in the bench, and directed cases pin down the exact expiry cycle and the restart-on-expiry race.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_RANGE = 8'h04;
  localparam logic [7:0] OFS_COUNT = 8'h08;
  localparam logic [7:0] OFS_KICK  = 8'h0C;
  localparam logic [7:0] OFS_STAT  = 8'h10;
  localparam logic [7:0] OFS_CLR   = 8'h14;
  localparam logic [7:0] OFS_PARAM = 8'hF4;

  localparam logic [7:0]  KICK_KEY  = 8'h76;
  localparam logic [31:0] PARAM_VAL = 32'h0000_0040;
  localparam int unsigned NUM_IDX   = 16;

  typedef enum logic [1:0] {
    WS_IDLE,
    WS_RUN,
    WS_FIRE,
    WS_HALT
  } wdt_state_e;
endpackage

// File: rtl/wdt_period_lut.sv
module wdt_period_lut #(
  parameter int unsigned BASE_EXP = 16,
  parameter int unsigned CNT_W    = BASE_EXP + 16
) (
  input  logic [3:0]       init_idx_i,
  input  logic [3:0]       run_idx_i,
  output logic [CNT_W-1:0] init_load_o,
  output logic [CNT_W-1:0] run_load_o
);
  logic [CNT_W-1:0] tbl [wdt_pkg::NUM_IDX];

  for (genvar g = 0; g < int'(wdt_pkg::NUM_IDX); g++) begin : g_tbl
    assign tbl[g] = CNT_W'((64'd1 << (BASE_EXP + g)) - 64'd1);
  end

  assign init_load_o = tbl[init_idx_i];
  assign run_load_o  = tbl[run_idx_i];
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              irq_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              en_o,
  output logic              mode_o,
  output logic [3:0]        init_idx_o,
  output logic [3:0]        run_idx_o,
  output logic              en_set_o,
  output logic              kick_o,
  output logic              irq_clr_o
);
  logic       en_q, mode_q;
  logic [7:0] range_q;
  logic       wr, rd;

  assign wr = req_i &  we_i;
  assign rd = req_i & ~we_i;

  assign en_set_o  = wr && addr_i == ADDR_W'(OFS_CTRL) && wdata_i[0] && !en_q;
  assign kick_o    = wr && addr_i == ADDR_W'(OFS_KICK) && wdata_i == DATA_W'(KICK_KEY);
  assign irq_clr_o = rd && addr_i == ADDR_W'(OFS_CLR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      mode_q  <= 1'b0;
      range_q <= '0;
    end else if (wr) begin
      if (addr_i == ADDR_W'(OFS_CTRL)) begin
        en_q   <= en_q | wdata_i[0];
        mode_q <= wdata_i[1];
      end
      if (addr_i == ADDR_W'(OFS_RANGE)) range_q <= wdata_i[7:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_W'(OFS_CTRL):  rdata_o = DATA_W'({mode_q, en_q});
      ADDR_W'(OFS_RANGE): rdata_o = DATA_W'(range_q);
      ADDR_W'(OFS_COUNT): rdata_o = DATA_W'(cnt_i);
      ADDR_W'(OFS_STAT):  rdata_o = DATA_W'(irq_i);
      ADDR_W'(OFS_PARAM): rdata_o = DATA_W'(PARAM_VAL);
      default:            rdata_o = '0;
    endcase
  end

  assign en_o       = en_q;
  assign mode_o     = mode_q;
  assign init_idx_o = range_q[7:4];
  assign run_idx_o  = range_q[3:0];
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned RST_CYC = 8,
  localparam int unsigned PW     = $clog2(RST_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_set_i,
  input  logic             kick_i,
  input  logic             irq_clr_i,
  input  logic             mode_i,
  input  logic [CNT_W-1:0] init_load_i,
  input  logic [CNT_W-1:0] run_load_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o,
  output logic             sys_rst_o,
  output logic             running_o,
  output logic             halted_o
);
  wdt_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PW-1:0]    pulse_q;
  logic             irq_q, rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= WS_IDLE;
      cnt_q   <= '0;
      pulse_q <= '0;
      irq_q   <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      unique case (st_q)
        WS_IDLE: begin
          if (en_set_i) begin
            cnt_q <= init_load_i;
            st_q  <= WS_RUN;
          end
        end
        WS_RUN: begin
          if (kick_i) begin
            // restart wins over a simultaneous expiry
            cnt_q <= run_load_i;
            irq_q <= 1'b0;
          end else if (cnt_q == '0) begin
            if (!mode_i || irq_q) begin
              st_q    <= WS_FIRE;
              rst_q   <= 1'b1;
              pulse_q <= PW'(RST_CYC - 1);
            end else begin
              irq_q <= 1'b1;
              cnt_q <= run_load_i;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
            if (irq_clr_i) irq_q <= 1'b0;
          end
        end
        WS_FIRE: begin
          if (irq_clr_i) irq_q <= 1'b0;
          if (pulse_q == '0) begin
            st_q  <= WS_HALT;
            rst_q <= 1'b0;
          end else begin
            pulse_q <= pulse_q - 1'b1;
          end
        end
        WS_HALT: begin
          if (irq_clr_i) irq_q <= 1'b0;
        end
        default: st_q <= WS_IDLE;
      endcase
    end
  end

  assign cnt_o     = cnt_q;
  assign irq_o     = irq_q;
  assign sys_rst_o = rst_q;
  assign running_o = st_q == WS_RUN;
  assign halted_o  = st_q == WS_HALT;
endmodule

// File: rtl/wdt_top.sv
module wdt_top #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned BASE_EXP = 16,
  parameter int unsigned RST_CYC  = 8,
  localparam int unsigned CNT_W   = BASE_EXP + 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              sys_rst_o
);
  logic             en, mode, en_set, kick, irq_clr;
  logic [3:0]       init_idx, run_idx;
  logic [CNT_W-1:0] init_load, run_load, cnt;
  logic             irq, sys_rst, running, halted;

  wdt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .cnt_i      (cnt),
    .irq_i      (irq),
    .rdata_o,
    .en_o       (en),
    .mode_o     (mode),
    .init_idx_o (init_idx),
    .run_idx_o  (run_idx),
    .en_set_o   (en_set),
    .kick_o     (kick),
    .irq_clr_o  (irq_clr)
  );

  wdt_period_lut #(.BASE_EXP(BASE_EXP), .CNT_W(CNT_W)) i_lut (
    .init_idx_i  (init_idx),
    .run_idx_i   (run_idx),
    .init_load_o (init_load),
    .run_load_o  (run_load)
  );

  wdt_counter #(.CNT_W(CNT_W), .RST_CYC(RST_CYC)) i_cnt (
    .clk_i, .rst_ni,
    .en_set_i    (en_set),
    .kick_i      (kick),
    .irq_clr_i   (irq_clr),
    .mode_i      (mode),
    .init_load_i (init_load),
    .run_load_i  (run_load),
    .cnt_o       (cnt),
    .irq_o       (irq),
    .sys_rst_o   (sys_rst),
    .running_o   (running),
    .halted_o    (halted)
  );

  assign irq_o     = irq;
  assign sys_rst_o = sys_rst;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned RST_CYC = 8,
  localparam int unsigned HW     = $clog2(RST_CYC + 2)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en,
  input logic             mode,
  input logic             kick,
  input logic             running,
  input logic             halted,
  input logic [CNT_W-1:0] cnt,
  input logic             irq,
  input logic             sys_rst
);
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hi_cnt <= '0;
    else if (!sys_rst) hi_cnt <= '0;
    else if (hi_cnt != {HW{1'b1}}) hi_cnt <= hi_cnt + 1'b1;
  end

  AST_EN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en |=> en); // R2

  AST_CNT_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running && cnt != '0 && !kick |=> running && cnt == CNT_W'($past(cnt) - 1'b1)); // R3

  AST_KICK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running && kick |=> !irq && !sys_rst); // R5

  AST_DIRECT_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running && cnt == '0 && !kick && !mode |=> sys_rst); // R6

  AST_PULSE_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_cnt <= HW'(RST_CYC)); // R6

  AST_FIRST_STAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running && cnt == '0 && !kick && mode && !irq |=> irq && running && !sys_rst); // R7

  AST_HALT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted |=> halted && !sys_rst && cnt == '0); // R9

  AST_RST_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst |-> en); // R6
endmodule

bind wdt_top wdt_checker #(.CNT_W(CNT_W), .RST_CYC(RST_CYC)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en      (en),
  .mode    (mode),
  .kick    (kick),
  .running (running),
  .halted  (halted),
  .cnt     (cnt),
  .irq     (irq),
  .sys_rst (sys_rst)
);

// File: tb/test_wdt_top.sv
`timescale 1ns/1ps
module test_wdt_top;
  localparam int BASE = 2;
  localparam int RCYC = 3;
  localparam int CW   = BASE + 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, sys_rst;

  int total = 0, bad = 0;
  logic obs_rst, obs_irq;
  logic [31:0] last_rd;

  always #2 clk = ~clk;

  wdt_top #(.ADDR_W(8), .DATA_W(32), .BASE_EXP(BASE), .RST_CYC(RCYC)) i_wdt_top (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .sys_rst_o(sys_rst)
  );

  // reference model, built from the requirements
  int          m_st;  // 0 idle 1 run 2 fire 3 halt
  logic        m_en, m_mode, m_irq, m_rst;
  logic [7:0]  m_rng;
  logic [CW-1:0] m_cnt;
  int          m_pulse;

  function automatic logic [CW-1:0] per(input logic [3:0] k);
    return CW'((64'd1 << (BASE + k)) - 64'd1);
  endfunction

  function automatic logic [31:0] m_rd(input logic [7:0] a);
    case (a)
      8'h00: return {30'd0, m_mode, m_en};
      8'h04: return {24'd0, m_rng};
      8'h08: return 32'(m_cnt);
      8'h10: return {31'd0, m_irq};
      8'hF4: return 32'h40;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_en = 0; m_mode = 0; m_irq = 0; m_rst = 0;
      m_rng = 0; m_cnt = 0; m_pulse = 0;
    end else begin
      logic k, c;
      k = req && we && addr == 8'h0C && wdata == 32'h76;
      c = req && !we && addr == 8'h14;
      case (m_st)
        0: if (req && we && addr == 8'h00 && wdata[0]) begin
             m_cnt = per(m_rng[7:4]); m_st = 1;
           end
        1: if (k) begin
             m_cnt = per(m_rng[3:0]); m_irq = 0;
           end else if (m_cnt == 0) begin
             if (!m_mode || m_irq) begin
               m_st = 2; m_rst = 1; m_pulse = RCYC;
             end else begin
               m_irq = 1; m_cnt = per(m_rng[3:0]);
             end
           end else begin
             m_cnt = m_cnt - 1;
             if (c) m_irq = 0;
           end
        2: begin
             if (c) m_irq = 0;
             m_pulse = m_pulse - 1;
             if (m_pulse == 0) begin m_st = 3; m_rst = 0; end
           end
        default: if (c) m_irq = 0;
      endcase
      if (req && we && addr == 8'h00) begin m_en = m_en | wdata[0]; m_mode = wdata[1]; end
      if (req && we && addr == 8'h04) m_rng = wdata[7:0];
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(input logic r, input logic w, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    obs_rst = sys_rst; obs_irq = irq;
    chk("R6/R7/R9 sys_rst vs model", 32'(sys_rst), 32'(m_rst));
    chk("R7/R8 irq vs model", 32'(irq), 32'(m_irq));
    req = r; we = w; addr = a; wdata = d;
    #1;
    if (r && !w) begin
      last_rd = rdata;
      chk("R1/R3/R11 rdata vs model", rdata, m_rd(a));
    end
  endtask

  task automatic idle();           step(1'b0, 1'b0, 8'h00, 32'h0); endtask
  task automatic wr(input logic [7:0] a, input logic [31:0] d); step(1'b1, 1'b1, a, d); endtask
  task automatic rd(input logic [7:0] a); step(1'b1, 1'b0, a, 32'h0); endtask

  task automatic do_reset();
    @(negedge clk);
    req = 0; we = 0; addr = 0; wdata = 0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int j;
    void'($urandom(32'd2024));

    // R1 / R11: reset state and parameter word
    do_reset();
    idle();
    chk("R1 sys_rst after reset", 32'(obs_rst), 0);
    chk("R1 irq after reset", 32'(obs_irq), 0);
    rd(8'h00); chk("R1 ctrl reset", last_rd, 0);
    rd(8'h08); chk("R1 count reset", last_rd, 0);
    rd(8'hF4); chk("R11 param word", last_rd, 32'h40);
    wr(8'hF4, 32'hFFFF_FFFF);
    rd(8'hF4); chk("R11 param read-only", last_rd, 32'h40);
    rd(8'h3C); chk("R11 unmapped reads 0", last_rd, 0);
    rd(8'h08); chk("R1 count idle", last_rd, 0);

    // R2 R3 R6 R9: direct mode, init idx 3 (32 cycles)
    wr(8'h04, 32'h31);
    wr(8'h00, 32'h1);
    rd(8'h08); chk("R3 first load", last_rd, 31);
    wr(8'h00, 32'h0);
    rd(8'h00); chk("R2 enable sticky", last_rd, 1);
    j = 3;
    do begin idle(); j++; end while (!obs_rst && j < 200);
    chk("R6 expiry cycle", j, 33);
    j = 0;
    while (obs_rst && j < 50) begin idle(); j++; end
    chk("R6 pulse length", j, RCYC);
    wr(8'h0C, 32'h76);
    repeat (20) idle();
    chk("R9 no further reset", 32'(obs_rst), 0);
    rd(8'h08); chk("R9 counter frozen", last_rd, 0);

    // R4 R10: restart key and range writes while running
    do_reset();
    wr(8'h04, 32'h44);
    wr(8'h00, 32'h1);
    rd(8'h08); chk("R3 load idx4", last_rd, 63);
    wr(8'h04, 32'h11);
    rd(8'h08); chk("R10 range write no effect on count", last_rd, 61);
    wr(8'h0C, 32'h75);
    wr(8'h0C, 32'h176);
    rd(8'h08); chk("R4 wrong key ignored", last_rd, 58);
    wr(8'h0C, 32'h76);
    rd(8'h08); chk("R4 R10 reload with new run idx", last_rd, 7);

    // R12: restart in the expiry cycle
    j = 0;
    do begin rd(8'h08); j++; end while (last_rd != 1 && j < 100);
    wr(8'h0C, 32'h76);
    rd(8'h08); chk("R12 restart wins over expiry", last_rd, 7);
    chk("R12 no reset", 32'(obs_rst), 0);

    // R7 R8 R5: two-stage mode, period 16
    do_reset();
    wr(8'h04, 32'h22);
    wr(8'h00, 32'h3);
    j = 0;
    do begin idle(); j++; end while (!obs_irq && j < 200);
    chk("R7 first expiry sets irq", j, 17);
    rd(8'h10); chk("R7 status bit", last_rd, 1);
    rd(8'h14);
    rd(8'h10); chk("R8 read clear", last_rd, 0);
    j = 0;
    do begin idle(); j++; end while (!obs_irq && !obs_rst && j < 200);
    chk("R8 next expiry only irq", 32'(obs_rst), 0);
    chk("R8 irq again", 32'(obs_irq), 1);
    wr(8'h0C, 32'h76);
    idle(); chk("R5 restart clears irq", 32'(obs_irq), 0);
    j = 0;
    do begin idle(); j++; end while (!obs_irq && j < 200);
    j = 0;
    do begin idle(); j++; end while (!obs_rst && j < 200);
    chk("R7 second expiry resets", j, 16);

    // index 15 load
    do_reset();
    wr(8'h04, 32'hF0);
    wr(8'h00, 32'h1);
    rd(8'h08); chk("R3 idx15 load", last_rd, 32'((1 << 17) - 1));

    // random traffic against the model
    for (int s = 0; s < 6; s++) begin
      do_reset();
      wr(8'h04, {24'd0, 1'b0, 3'($urandom_range(0, 4)), 1'b0, 3'($urandom_range(0, 4))});
      wr(8'h00, {30'd0, 1'($urandom), 1'b1});
      for (int n = 0; n < 1500; n++) begin
        int p;
        p = $urandom_range(0, 99);
        if (p < 50) idle();
        else if (p < 60) wr(8'h0C, 32'h76);
        else if (p < 65) wr(8'h0C, $urandom_range(0, 255) | 32'h100);
        else if (p < 83) rd(8'(4 * $urandom_range(0, 5)));
        else if (p < 88) rd(8'h14);
        else if (p < 92) wr(8'h00, 32'($urandom_range(0, 3)));
        else if (p < 96) wr(8'h04, {24'd0, 1'b0, 3'($urandom_range(0, 4)), 1'b0, 3'($urandom_range(0, 4))});
        else rd(8'hF4);
      end
    end

    idle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule